// File: doc/BRIEF.md
# Cascadable Unsigned Magnitude Comparator

This block compares two unsigned operands of a configurable width and reports the outcome on two wires: one meaning "greater" and one meaning "equal". When both are low, the first operand is smaller. It is purely combinational. The comparison starts at the most significant bit and works down toward bit 0. Each stage passes a greater/equal pair to the next less significant stage. The result is the pair that leaves the least significant stage.

The block has two internal forms, and a parameter picks one of them. The ripple form chains one small cell per bit. The grouped form splits the operands into three-bit groups. Each group resolves all three of its bit pairs at once and then passes its greater/equal pair to the next group down. When the width is not a multiple of three, the top group is filled with zero bits on both operands. Because both operands get the same zero bits, those positions always compare equal.

The inputs that feed the most significant stage are brought out as ports. Wider comparisons can then be built by chaining instances: feed the outputs of the more significant instance into the cascade inputs of the next one. A standalone instance ties these inputs to greater=0 and equal=1.

Top module: `mag_cmp_cascade`

## Requirements
- R1: With cascade inputs greater=0 and equal=1, an operand A larger than B drives gt=1 and eq=0.
- R2: eq is 1 exactly when A equals B and the cascade equal input is 1; with the standalone cascade setting and equal operands, gt=0 and eq=1.
- R3: With the standalone cascade setting, an operand A smaller than B drives gt=0 and eq=0.
- R4: For any legal cascade input (greater and equal never both 1), gt and eq are never 1 together.
- R5: Cascade inputs greater=1 and equal=0 force gt=1 and eq=0, whatever the operands are.
- R6: Cascade inputs greater=0 and equal=0 force gt=0 and eq=0, whatever the operands are.
- R7: The ripple form (GROUPED=0) and the grouped form (GROUPED=1) produce identical gt and eq for every operand pair and every legal cascade input.
- R8: The highest bit position where A and B differ alone decides the result; lower bits cannot override it (for example 0x80 against 0x7F gives gt=1).
- R9: In the grouped form, widths that are not a multiple of three (such as 4 and 5) compare correctly. The zero bits that fill the top group never change the outcome.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First unsigned operand |
| b | input | WIDTH | Second unsigned operand |
| gt_in | input | 1 | Greater flag from a more significant stage; tie to 0 when standalone |
| eq_in | input | 1 | Equal flag from a more significant stage; tie to 1 when standalone |
| gt | output | 1 | 1 when the cascaded value of A is greater than that of B |
| eq | output | 1 | 1 when the cascaded values of A and B are equal |

## Verification
The bench builds five instances: the ripple and grouped forms at width 8, the ripple and grouped forms at width 5, and the grouped form at width 4. At widths 4 and 5, every operand pair can be tried under each of the three legal cascade settings. That sweep covers every placement of the top-group padding. At width 8, a fixed vector table and random operands exercise the two forms side by side. This brings the deciding-bit cases at both the top and the bottom of the word within reach, along with the equivalence of the two forms.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    // Greater/equal pair passed from a more significant stage to a less significant one.
    typedef struct packed {
        logic gt;
        logic eq;
    } cmp_link_t;

    // Number of operand bits that one lookahead group resolves.
    localparam int unsigned GROUP_BITS = 3;

endpackage

// File: rtl/cmp_bit_cell.sv
module cmp_bit_cell
    import cmp_pkg::*;
(
    input  logic      a_bit,
    input  logic      b_bit,
    input  cmp_link_t up,
    output cmp_link_t dn
);

    logic same;

    always_comb begin
        same  = ~(a_bit ^ b_bit);
        // Once a more significant stage reports greater, that result stands.
        // A win at this bit only counts if every bit above it matched.
        dn.gt = up.gt | (a_bit & ~b_bit & up.eq);
        dn.eq = same & up.eq;
    end

endmodule

// File: rtl/cmp_group3.sv
module cmp_group3
    import cmp_pkg::*;
(
    input  logic [2:0] a_grp,
    input  logic [2:0] b_grp,
    input  cmp_link_t  up,
    output cmp_link_t  dn
);

    logic [2:0] same;
    logic [2:0] wins;
    logic       grp_win;

    always_comb begin
        same = ~(a_grp ^ b_grp);
        wins = a_grp & ~b_grp;
        // Flat sum of products across the group: no bit-to-bit ripple inside it.
        grp_win = wins[2]
                | (same[2] & wins[1])
                | (same[2] & same[1] & wins[0]);
        dn.gt = up.gt | (up.eq & grp_win);
        dn.eq = up.eq & (&same);
    end

endmodule

// File: rtl/mag_cmp_cascade.sv
module mag_cmp_cascade
    import cmp_pkg::*;
#(
    parameter int unsigned WIDTH   = 8,
    parameter bit          GROUPED = 1'b0
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             gt_in,
    input  logic             eq_in,
    output logic             gt,
    output logic             eq
);

    cmp_link_t result;

    generate
        if (!GROUPED) begin : g_ripple
            cmp_link_t [WIDTH:0] chain;

            assign chain[WIDTH] = '{gt: gt_in, eq: eq_in};

            for (genvar i = 0; i < WIDTH; i++) begin : g_bit
                cmp_bit_cell u_cell (
                    .a_bit (a[i]),
                    .b_bit (b[i]),
                    .up    (chain[i+1]),
                    .dn    (chain[i])
                );
            end

            assign result = chain[0];
        end else begin : g_grouped
            localparam int unsigned NGRP = (WIDTH + GROUP_BITS - 1) / GROUP_BITS;
            localparam int unsigned PADW = NGRP * GROUP_BITS;

            logic [PADW-1:0]    a_pad;
            logic [PADW-1:0]    b_pad;
            cmp_link_t [NGRP:0] chain;

            // Both operands get the same zero bits on top, so the padding compares equal.
            assign a_pad       = PADW'(a);
            assign b_pad       = PADW'(b);
            assign chain[NGRP] = '{gt: gt_in, eq: eq_in};

            for (genvar g = 0; g < NGRP; g++) begin : g_grp
                cmp_group3 u_grp (
                    .a_grp (a_pad[g*GROUP_BITS +: GROUP_BITS]),
                    .b_grp (b_pad[g*GROUP_BITS +: GROUP_BITS]),
                    .up    (chain[g+1]),
                    .dn    (chain[g])
                );
            end

            assign result = chain[0];
        end
    endgenerate

    assign gt = result.gt;
    assign eq = result.eq;

endmodule

module mag_cmp_cascade_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             gt_in,
    input logic             eq_in,
    input logic             gt,
    input logic             eq
);

    logic known;
    logic legal;

    always_comb begin
        known = !$isunknown({a, b, gt_in, eq_in, gt, eq});
        legal = !(gt_in && eq_in);
        if (known && legal) begin
            AST_EXCLUSIVE: assert (!(gt && eq)) else $error("gt and eq both high"); // R4
            AST_GT_MATCH: assert (gt == (gt_in || (eq_in && (a > b)))) else $error("gt mismatch"); // R1
            AST_UPPER_LT: assert (gt_in || eq_in || (!gt && !eq)) else $error("upper-less not propagated"); // R6
            AST_UPPER_GT: assert (!gt_in || (gt && !eq)) else $error("upper-greater not propagated"); // R5
        end
        if (known) begin
            AST_EQ_MATCH: assert (eq == (eq_in && (a == b))) else $error("eq mismatch"); // R2
        end
    end

endmodule

bind mag_cmp_cascade mag_cmp_cascade_chk #(.WIDTH(WIDTH)) u_chk (
    .a     (a),
    .b     (b),
    .gt_in (gt_in),
    .eq_in (eq_in),
    .gt    (gt),
    .eq    (eq)
);

// File: tb/mag_cmp_cascade_bench.sv
`timescale 1ns/1ps
module mag_cmp_cascade_bench;

    localparam time TCK = 4ns;

    logic clk = 1'b0;
    always #(TCK/2) clk = ~clk;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // Width-8 pair: ripple (main instance) and grouped.
    logic [7:0] a8, b8;
    logic gi8, ei8;
    logic gt_r8, eq_r8, gt_g8, eq_g8;
    // Width-5 pair and width-4 grouped.
    logic [4:0] a5, b5;
    logic [3:0] a4, b4;
    logic gi_s, ei_s;
    logic gt_r5, eq_r5, gt_g5, eq_g5, gt_g4, eq_g4;

    mag_cmp_cascade #(.WIDTH(8), .GROUPED(1'b0)) u_mag_cmp_cascade (
        .a(a8), .b(b8), .gt_in(gi8), .eq_in(ei8), .gt(gt_r8), .eq(eq_r8));
    mag_cmp_cascade #(.WIDTH(8), .GROUPED(1'b1)) u_grp8 (
        .a(a8), .b(b8), .gt_in(gi8), .eq_in(ei8), .gt(gt_g8), .eq(eq_g8));
    mag_cmp_cascade #(.WIDTH(5), .GROUPED(1'b0)) u_rip5 (
        .a(a5), .b(b5), .gt_in(gi_s), .eq_in(ei_s), .gt(gt_r5), .eq(eq_r5));
    mag_cmp_cascade #(.WIDTH(5), .GROUPED(1'b1)) u_grp5 (
        .a(a5), .b(b5), .gt_in(gi_s), .eq_in(ei_s), .gt(gt_g5), .eq(eq_g5));
    mag_cmp_cascade #(.WIDTH(4), .GROUPED(1'b1)) u_grp4 (
        .a(a4), .b(b4), .gt_in(gi_s), .eq_in(ei_s), .gt(gt_g4), .eq(eq_g4));

    // Fields: a[19:12] b[11:4] gt_in[3] eq_in[2] exp_gt[1] exp_eq[0]
    localparam int NVEC = 13;
    localparam logic [19:0] VECS [0:NVEC-1] = '{
        {8'h80, 8'h7F, 1'b0, 1'b1, 1'b1, 1'b0},  // R8 top bit decides
        {8'h7F, 8'h80, 1'b0, 1'b1, 1'b0, 1'b0},  // R8
        {8'hA5, 8'hA5, 1'b0, 1'b1, 1'b0, 1'b1},  // R2
        {8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1},  // R2
        {8'hFF, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b1},  // R2
        {8'hFF, 8'hFE, 1'b0, 1'b1, 1'b1, 1'b0},  // R1 bottom bit decides
        {8'h01, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0},  // R1
        {8'h00, 8'h01, 1'b0, 1'b1, 1'b0, 1'b0},  // R3
        {8'h5A, 8'h5B, 1'b0, 1'b1, 1'b0, 1'b0},  // R3
        {8'h12, 8'h34, 1'b1, 1'b0, 1'b1, 1'b0},  // R5
        {8'h55, 8'h55, 1'b1, 1'b0, 1'b1, 1'b0},  // R5
        {8'h34, 8'h12, 1'b0, 1'b0, 1'b0, 1'b0},  // R6
        {8'h55, 8'h55, 1'b0, 1'b0, 1'b0, 1'b0}   // R6
    };

    task automatic chk(input string req, input logic got_gt, input logic got_eq,
                       input logic exp_gt, input logic exp_eq);
        checks++;
        if (got_gt !== exp_gt || got_eq !== exp_eq) begin
            errors++;
            $display("FAIL %s: gt/eq actual %b%b expected %b%b", req, got_gt, got_eq, exp_gt, exp_eq);
        end
    endtask

    // Reference built from the language's own relational operators.
    function automatic logic [1:0] ref_cmp(input int unsigned x, input int unsigned y,
                                           input logic gi, input logic ei);
        if (gi)       return 2'b10;
        else if (!ei) return 2'b00;
        else if (x > y) return 2'b10;
        else if (x == y) return 2'b01;
        else return 2'b00;
    endfunction

    function automatic string req_of(input logic [1:0] cas, input logic [1:0] exp);
        if (cas == 2'b10) return "R5";
        if (cas == 2'b00) return "R6";
        if (exp == 2'b10) return "R1";
        if (exp == 2'b01) return "R2";
        return "R3";
    endfunction

    initial begin
        logic [1:0] e;
        a8 = '0; b8 = '0; gi8 = 1'b0; ei8 = 1'b1;
        a5 = '0; b5 = '0; a4 = '0; b4 = '0; gi_s = 1'b0; ei_s = 1'b1;

        // Idle state: zero operands, standalone cascade -> equal.
        @(negedge clk);
        chk("R2 idle ripple", gt_r8, eq_r8, 1'b0, 1'b1);
        chk("R2 idle grouped", gt_g8, eq_g8, 1'b0, 1'b1);

        // Vector table.
        for (int i = 0; i < NVEC; i++) begin
            @(posedge clk);
            {a8, b8, gi8, ei8} = VECS[i][19:2];
            @(negedge clk);
            chk(req_of({VECS[i][3], VECS[i][2]}, VECS[i][1:0]), gt_r8, eq_r8, VECS[i][1], VECS[i][0]);
            chk("R7 table grouped", gt_g8, eq_g8, VECS[i][1], VECS[i][0]);
        end

        // Random width-8 operands; ripple and grouped compared to reference and to each other.
        for (int i = 0; i < 400; i++) begin
            @(posedge clk);
            a8 = 8'($urandom);
            b8 = (i % 4 == 0) ? a8 : 8'($urandom);
            case (i % 3)
                0: begin gi8 = 1'b0; ei8 = 1'b1; end
                1: begin gi8 = 1'b1; ei8 = 1'b0; end
                default: begin gi8 = 1'b0; ei8 = 1'b0; end
            endcase
            @(negedge clk);
            e = ref_cmp(a8, b8, gi8, ei8);
            chk(req_of({gi8, ei8}, e), gt_r8, eq_r8, e[1], e[0]);
            chk("R7 grouped vs ripple", gt_g8, eq_g8, gt_r8, eq_r8);
            chk("R4 exclusive", gt_r8 & eq_r8, 1'b0, 1'b0, 1'b0);
        end
        gi8 = 1'b0; ei8 = 1'b1;

        // Exhaustive widths 5 and 4 under every legal cascade setting.
        for (int c = 0; c < 3; c++) begin
            for (int x = 0; x < 32; x++) begin
                for (int y = 0; y < 32; y++) begin
                    @(posedge clk);
                    gi_s = (c == 1);
                    ei_s = (c == 0);
                    a5 = 5'(x); b5 = 5'(y);
                    a4 = 4'(x); b4 = 4'(y);
                    @(negedge clk);
                    e = ref_cmp(x, y, gi_s, ei_s);
                    chk(req_of({gi_s, ei_s}, e), gt_r5, eq_r5, e[1], e[0]);
                    chk("R9 grouped width 5", gt_g5, eq_g5, e[1], e[0]);
                    chk("R7 width 5 forms", gt_g5, eq_g5, gt_r5, eq_r5);
                    if (x < 16 && y < 16) begin
                        e = ref_cmp(x, y, gi_s, ei_s);
                        chk("R9 grouped width 4", gt_g4, eq_g4, e[1], e[0]);
                    end
                end
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual running expected done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule